// File: doc/BRIEF.md
# Dual-Channel Converter Input Formatter

This block is the synchronous digital front end of a dual 16-bit converter with an I channel and a Q channel. On every converter clock it samples two 16-bit input buses and routes them to the channels according to the port mode. In dual-port mode each bus feeds its own channel. In interleaved mode a single bus carries words for both channels, and a channel-select line steers each word.

Each captured word is first converted to the unsigned offset-binary code that the current-steering array uses. Two's-complement input has its most significant bit flipped, and straight-binary input passes through as is. After conversion the word can be complemented. The outputs are two registered channel codes and a one-clock valid strobe. In interleaved mode the two codes are released together once both halves of a pair have been captured, so the channels stay aligned in time. Power-down forces both codes to mid-scale.

Top module: `dac_in_fmt`

## Requirements
- R1: While reset is asserted, and until the first clocked sample after reset, both channel codes read 16'h8000 and valid_o is low.
- R2: With dual_port_i high and pwr_dn_i low, the edge that samples the inputs loads chan_i_o from bus_b_i and chan_q_o from bus_a_i, after conversion, and drives valid_o high for that cycle.
- R3: With twos_i high, bit 15 of each word is flipped (16'h0000 becomes 16'h8000, 16'hFFFF becomes 16'h7FFF). With twos_i low, the word passes unchanged.
- R4: With invert_i high, all 16 bits are complemented after the format conversion of R3.
- R5: With dual_port_i low, a bus_b_i word goes to the I half when chan_sel_i is 1 and to the Q half when it is 0. bus_a_i has no effect on either output.
- R6: In interleaved mode, the outputs change and valid_o pulses for one cycle only on the sample that completes a pair (one I word and one Q word, in either order). On every other cycle both outputs hold and valid_o stays low.
- R7: In interleaved mode, a second word for a half that is already pending replaces the earlier one.
- R8: In dual-port mode chan_sel_i has no effect on the outputs.
- R9: A sample with pwr_dn_i high sets both codes to 16'h8000, keeps valid_o low, and discards any pending half-pair.
- R10: A sample taken in dual-port mode discards any pending interleaved half-pair, so leaving interleaved mode and returning starts a new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_port_i | input | 1 | 1: dual-port, 0: single-port interleaved |
| chan_sel_i | input | 1 | Interleaved steering: 1 selects I, 0 selects Q |
| twos_i | input | 1 | 1: two's-complement input, 0: straight binary |
| invert_i | input | 1 | 1: complement the data after conversion |
| pwr_dn_i | input | 1 | 1: power-down, outputs at mid-scale |
| bus_a_i | input | 16 | Q data in dual-port mode; unused when interleaved |
| bus_b_i | input | 16 | I data in dual-port mode; the shared bus when interleaved |
| chan_i_o | output | 16 | Registered I channel code |
| chan_q_o | output | 16 | Registered Q channel code |
| valid_o | output | 1 | One-cycle strobe for a new code pair |

## Verification
Dual-port words are chosen with distinct I and Q values and swept across all four format and invert combinations, including the all-zero and all-one words. This separates a swapped bus from a missing MSB flip and from inversion applied in the wrong order. Interleaved runs pair Q-then-I and I-then-Q while the A bus carries noise. They also repeat one half before completing the pair, which shows whether the latest word or the first one is kept. Power-down and a brief switch to dual-port are each inserted between the two halves of a pair, to confirm that the stale half is dropped rather than paired.

// File: rtl/dac_fmt_pkg.sv
package dac_fmt_pkg;
  localparam int unsigned CODE_W = 16;

  typedef enum logic {
    CH_Q = 1'b0,
    CH_I = 1'b1
  } chan_e;
endpackage

// File: rtl/dac_fmt_conv.sv
module dac_fmt_conv #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] data_i,
  input  logic         twos_i,
  input  logic         invert_i,
  output logic [W-1:0] code_o
);
  logic [W-1:0] offs;

  always_comb begin
    offs = data_i;
    if (twos_i) offs[W-1] = ~data_i[W-1];
    code_o = invert_i ? ~offs : offs;
  end
endmodule

// File: rtl/dac_fmt_pair.sv
module dac_fmt_pair
  import dac_fmt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  chan_e        sel_i,
  input  logic [W-1:0] word_i,
  output logic         done_o,
  output logic [W-1:0] held_i_o,
  output logic [W-1:0] held_q_o
);
  logic got_i, got_q;

  assign done_o = load_i && ((sel_i == CH_I) ? got_q : got_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_i    <= 1'b0;
      got_q    <= 1'b0;
      held_i_o <= '0;
      held_q_o <= '0;
    end else if (clr_i || done_o) begin
      got_i <= 1'b0;
      got_q <= 1'b0;
    end else if (load_i) begin
      if (sel_i == CH_I) begin
        held_i_o <= word_i;
        got_i    <= 1'b1;
      end else begin
        held_q_o <= word_i;
        got_q    <= 1'b1;
      end
    end
  end

  assert_one_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(got_i && got_q));

  assert_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!got_i && !got_q));
endmodule

// File: rtl/dac_in_fmt.sv
module dac_in_fmt
  import dac_fmt_pkg::*;
#(
  parameter int unsigned W = CODE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dual_port_i,
  input  logic         chan_sel_i,
  input  logic         twos_i,
  input  logic         invert_i,
  input  logic         pwr_dn_i,
  input  logic [W-1:0] bus_a_i,
  input  logic [W-1:0] bus_b_i,
  output logic [W-1:0] chan_i_o,
  output logic [W-1:0] chan_q_o,
  output logic         valid_o
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
  localparam int unsigned  NBUS = 2;

  logic [NBUS-1:0][W-1:0] raw, conv;
  logic [W-1:0] held_i, held_q;
  logic         done, clr, load;
  chan_e        sel;

  assign raw[0] = bus_a_i;
  assign raw[1] = bus_b_i;

  for (genvar g = 0; g < NBUS; g++) begin : g_conv
    dac_fmt_conv #(.W(W)) u_conv (
      .data_i  (raw[g]),
      .twos_i  (twos_i),
      .invert_i(invert_i),
      .code_o  (conv[g])
    );
  end

  assign sel  = chan_sel_i ? CH_I : CH_Q;
  assign clr  = pwr_dn_i || dual_port_i;
  assign load = !clr;

  dac_fmt_pair #(.W(W)) u_pair (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .load_i  (load),
    .sel_i   (sel),
    .word_i  (conv[1]),
    .done_o  (done),
    .held_i_o(held_i),
    .held_q_o(held_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_i_o <= MID;
      chan_q_o <= MID;
      valid_o  <= 1'b0;
    end else if (pwr_dn_i) begin
      chan_i_o <= MID;
      chan_q_o <= MID;
      valid_o  <= 1'b0;
    end else if (dual_port_i) begin
      chan_i_o <= conv[1];
      chan_q_o <= conv[0];
      valid_o  <= 1'b1;
    end else if (done) begin
      // completing word pairs with the stored opposite half
      chan_i_o <= (sel == CH_I) ? conv[1] : held_i;
      chan_q_o <= (sel == CH_I) ? held_q  : conv[1];
      valid_o  <= 1'b1;
    end else begin
      valid_o  <= 1'b0;
    end
  end

  assert_pd_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> (chan_i_o == MID && chan_q_o == MID && !valid_o));

  assert_dual_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_dn_i && dual_port_i) |=> valid_o);

  assert_pair_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_dn_i && !dual_port_i && !done) |=>
      (!valid_o && $stable(chan_i_o) && $stable(chan_q_o)));
endmodule

// File: tb/dac_in_fmt_test.sv
`timescale 1ns/1ps
module dac_in_fmt_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dual_port_i = 1'b0, chan_sel_i = 1'b0, twos_i = 1'b0;
  logic        invert_i = 1'b0, pwr_dn_i = 1'b0;
  logic [15:0] bus_a_i = '0, bus_b_i = '0;
  logic [15:0] chan_i_o, chan_q_o;
  logic        valid_o;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  typedef struct {
    logic [15:0] ci, cq;
    logic        v;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference model state
  logic [15:0] m_i = 16'h8000, m_q = 16'h8000, h_i, h_q;
  bit p_i = 0, p_q = 0;

  always #2 clk_i = ~clk_i;

  dac_in_fmt uut (.*);

  function automatic logic [15:0] cv(logic [15:0] d, logic t, logic n);
    logic [15:0] w = d;
    if (t) w[15] = ~w[15];
    return n ? ~w : w;
  endfunction

  task automatic check(string tag, logic [15:0] ci, logic [15:0] cq, logic v);
    n_run++;
    if (chan_i_o !== ci || chan_q_o !== cq || valid_o !== v) begin
      n_fail++;
      $display("FAIL %s: actual i=%h q=%h v=%b expected i=%h q=%h v=%b",
               tag, chan_i_o, chan_q_o, valid_o, ci, cq, v);
    end
  endtask

  task automatic step(bit dp, bit sel, bit t, bit n, bit pd,
                      logic [15:0] a, logic [15:0] b, string tag);
    exp_t e;
    logic [15:0] wb;
    dual_port_i = dp; chan_sel_i = sel; twos_i = t; invert_i = n;
    pwr_dn_i = pd; bus_a_i = a; bus_b_i = b;
    @(posedge clk_i);
    wb = cv(b, t, n);
    e.v = 1'b0;
    if (pd) begin
      m_i = 16'h8000; m_q = 16'h8000; p_i = 0; p_q = 0;
    end else if (dp) begin
      m_i = wb; m_q = cv(a, t, n); e.v = 1'b1; p_i = 0; p_q = 0;
    end else if (sel) begin
      if (p_q) begin m_i = wb; m_q = h_q; e.v = 1'b1; p_q = 0; p_i = 0; end
      else begin h_i = wb; p_i = 1; end
    end else begin
      if (p_i) begin m_q = wb; m_i = h_i; e.v = 1'b1; p_i = 0; p_q = 0; end
      else begin h_q = wb; p_q = 1; end
    end
    e.ci = m_i; e.cq = m_q; e.tag = tag;
    sb.push_back(e);
    @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, e.ci, e.cq, e.v);
    end
  end

  initial begin
    #(4 * 200000);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", 16'h8000, 16'h8000, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", 16'h8000, 16'h8000, 1'b0);

    // dual-port routing, format and invert
    step(1, 0, 0, 0, 0, 16'h1234, 16'hABCD, "R2 dual binary");
    step(1, 1, 0, 0, 0, 16'h1234, 16'hABCD, "R8 sel ignored in dual");
    step(1, 0, 1, 0, 0, 16'hFFFF, 16'h0000, "R3 twos edge words");
    step(1, 1, 1, 0, 0, 16'h7FFF, 16'h8001, "R3 twos mid words");
    step(1, 0, 0, 1, 0, 16'h00FF, 16'h0F0F, "R4 invert binary");
    step(1, 0, 1, 1, 0, 16'hFFFF, 16'h0000, "R4 invert after twos");
    step(1, 1, 1, 1, 0, 16'h5A5A, 16'hC3C3, "R8 sel ignored all modes");

    // interleaved pairing
    step(0, 0, 0, 0, 0, 16'hDEAD, 16'h1111, "R6 Q half holds");
    step(0, 1, 0, 0, 0, 16'hBEEF, 16'h2222, "R5 Q then I pair");
    step(0, 1, 1, 0, 0, 16'h0000, 16'h3333, "R6 I half holds");
    step(0, 0, 1, 0, 0, 16'hFFFF, 16'h4444, "R5 I then Q pair");
    step(0, 0, 0, 1, 0, 16'h5555, 16'h0001, "R7 first Q");
    step(0, 0, 0, 1, 0, 16'hAAAA, 16'h0002, "R7 Q replaced");
    step(0, 1, 0, 1, 0, 16'h5555, 16'h0003, "R7 pair uses latest Q");

    // power-down between halves
    step(0, 0, 0, 0, 0, 16'h0000, 16'h6666, "R6 pending Q");
    step(0, 0, 0, 0, 1, 16'h0000, 16'h7777, "R9 power-down idle");
    step(0, 1, 0, 0, 0, 16'h0000, 16'h8888, "R9 pending dropped");
    step(0, 0, 0, 0, 0, 16'h0000, 16'h9999, "R9 new pair completes");

    // mode change between halves
    step(0, 0, 0, 0, 0, 16'h0000, 16'hAAAA, "R10 pending Q");
    step(1, 0, 0, 0, 0, 16'h0102, 16'h0304, "R10 dual interlude");
    step(0, 1, 0, 0, 0, 16'hFFFF, 16'hBBBB, "R10 I not paired with stale Q");
    step(0, 0, 0, 0, 0, 16'hFFFF, 16'hCCCC, "R10 fresh pair");
    step(1, 0, 0, 0, 1, 16'h1234, 16'h4321, "R9 power-down in dual");

    repeat (2) @(negedge clk_i);
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule